// File: doc/BRIEF.md
# Divided countdown timer with vector entry

The block is a programmable countdown timer. A free-running base clock enable is passed through a prescaler whose ratio comes from a divide register, and every divided tick takes a fixed step off a current-count register. When the count cannot absorb a full step the timer expires: it raises a one-cycle interrupt request carrying the vector number held in its vector entry, unless that entry is masked.

Software writes the initial count, the divide setting, the vector entry and a global enable through a simple register port; the current count is read back through the same port. The vector entry picks one-shot or periodic behaviour. In periodic mode the count is reloaded from the initial count, reduced by whatever part of the expiring step was left over, so the long-run period stays exact. While the global enable is clear, every vector-entry write is stored masked.

Top module: `div_countdown_timer`

## Requirements
- R1: The divide register's bits 3, 1 and 0 form a code {bit3,bit1,bit0}: 000 divides by 2, 001 by 4, 010 by 8, 011 by 16, 100 by 32, 101 by 64, 110 by 128 and 111 by 1; bit 2 is ignored and reads back as 0. A divided tick occurs on the base tick that completes the selected number of base ticks.
- R2: Writing the initial count (address 2) loads the current count with the written value and restarts the prescaler from zero.
- R3: With an initial count of zero the current count never changes and no interrupt is raised.
- R4: Each divided tick subtracts TICK_STEP (default 4) from the current count while the count exceeds TICK_STEP; a tick that finds the count at or below TICK_STEP is an expiry.
- R5: In one-shot mode (mode bit 0) an expiry sets the current count to 0, after which the count stays 0 and no further interrupt is raised until the initial count is written again.
- R6: In periodic mode (mode bit 1) an expiry reloads the current count with the initial count minus (TICK_STEP minus the count before the tick), or 0 if that difference is not positive.
- R7: An expiry with the mask bit clear sets irq_o for exactly the one cycle after the expiring tick edge, with irq_vec_o equal to the vector field; with the mask bit set no interrupt is raised.
- R8: Bit 0 of the control register (address 0) is the global enable; while it is 0, a write to the vector entry stores the mask bit as 1 regardless of the written value.
- R9: After reset the vector entry reads as masked, vector 0, one-shot; the global enable, both counts and the divide code read as 0.
- R10: Writes to the current-count register (address 3) do not change it, and a divide write changes the ratio without clearing the prescaler count.
- R11: Register map: 0 control, 1 vector entry (vector in bits 7:0, mask in bit 16, mode in bit 17), 2 initial count, 3 current count, 4 divide; reads are combinational and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_tick_i | input | 1 | Base clock enable fed to the prescaler |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Interrupt request pulse |
| irq_vec_o | output | VEC_W | Vector posted with the request |

## Verification
The hardest situation to reach is a periodic expiry in which the count before the tick is strictly between zero and the step, so the reload is shortened by a non-zero leftover, and in particular the case where the leftover reaches or exceeds the initial count so the reload floors at zero and the next tick expires again. Directed phases program small initial counts (2, 6, 10) with divide-by-1 so these leftovers arise within a few cycles, and the random phase mixes small counts, every divide code and mid-count divide changes against a cycle-accurate bench model.

// File: rtl/div_timer_pkg.sv
package div_timer_pkg;
  typedef enum logic [2:0] {
    ADDR_CTRL = 3'd0,
    ADDR_VEC  = 3'd1,
    ADDR_INIT = 3'd2,
    ADDR_CUR  = 3'd3,
    ADDR_DIV  = 3'd4
  } reg_addr_e;

  localparam int DATA_W    = 32;
  localparam int MASK_BIT  = 16;
  localparam int MODE_BIT  = 17;
  localparam int MAX_SHIFT = 7;

  // code 3'b111 selects divide-by-1, others 2^(code+1)
  function automatic logic [2:0] div_shift(input logic [2:0] code);
    return (code == 3'b111) ? 3'd0 : code + 3'd1;
  endfunction
endpackage

// File: rtl/div_timer_prescaler.sv
module div_timer_prescaler
  import div_timer_pkg::*;
#(
  parameter int PRE_W = MAX_SHIFT
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       base_tick_i,
  input  logic [2:0] shift_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] last;

  assign last   = ~({PRE_W{1'b1}} << shift_i);
  // >= so a ratio shrunk mid-count fires on the next base tick
  assign tick_o = base_tick_i && !restart_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (restart_i)   cnt_q <= '0;
    else if (base_tick_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/div_timer_counter.sv
module div_timer_counter #(
  parameter int CNT_W     = 32,
  parameter int VEC_W     = 8,
  parameter int TICK_STEP = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic             masked_i,
  input  logic [VEC_W-1:0] vec_i,
  output logic [CNT_W-1:0] init_o,
  output logic [CNT_W-1:0] cur_o,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(TICK_STEP);

  logic [CNT_W-1:0] init_q, cur_q, leftover, reload;
  logic             running, expire;

  assign running  = (init_q != '0) && (periodic_i || cur_q != '0);
  assign expire   = tick_i && running && (cur_q <= STEP);
  assign leftover = STEP - cur_q;
  assign reload   = (init_q > leftover) ? init_q - leftover : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q    <= '0;
      cur_q     <= '0;
      irq_o     <= 1'b0;
      irq_vec_o <= '0;
    end else begin
      irq_o <= expire && !masked_i;
      if (expire) irq_vec_o <= vec_i;
      if (load_i) begin
        init_q <= load_val_i;
        cur_q  <= load_val_i;
      end else if (expire) begin
        cur_q <= periodic_i ? reload : '0;
      end else if (tick_i && running) begin
        cur_q <= cur_q - STEP;
      end
    end
  end

  assign init_o = init_q;
  assign cur_o  = cur_q;
endmodule

// File: rtl/div_timer_regs.sv
module div_timer_regs
  import div_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  init_i,
  input  logic [CNT_W-1:0]  cur_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sw_en_o,
  output logic              masked_o,
  output logic              periodic_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic [2:0]        shift_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o
);
  reg_addr_e  addr;
  logic       sw_en_q, mask_q, per_q;
  logic [VEC_W-1:0] vec_q;
  logic [2:0] code_q;

  assign addr = reg_addr_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_en_q <= 1'b0;
      mask_q  <= 1'b1;
      per_q   <= 1'b0;
      vec_q   <= '0;
      code_q  <= '0;
    end else if (we_i) begin
      unique case (addr)
        ADDR_CTRL: sw_en_q <= wdata_i[0];
        ADDR_VEC: begin
          vec_q  <= wdata_i[VEC_W-1:0];
          mask_q <= wdata_i[MASK_BIT] | ~sw_en_q;
          per_q  <= wdata_i[MODE_BIT];
        end
        ADDR_DIV: code_q <= {wdata_i[3], wdata_i[1:0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      ADDR_CTRL: rdata_o[0] = sw_en_q;
      ADDR_VEC: begin
        rdata_o[VEC_W-1:0] = vec_q;
        rdata_o[MASK_BIT]  = mask_q;
        rdata_o[MODE_BIT]  = per_q;
      end
      ADDR_INIT: rdata_o = DATA_W'(init_i);
      ADDR_CUR:  rdata_o = DATA_W'(cur_i);
      ADDR_DIV:  rdata_o[3:0] = {code_q[2], 1'b0, code_q[1:0]};
      default: ;
    endcase
  end

  assign sw_en_o    = sw_en_q;
  assign masked_o   = mask_q;
  assign periodic_o = per_q;
  assign vec_o      = vec_q;
  assign shift_o    = div_shift(code_q);
  assign load_o     = we_i && (addr == ADDR_INIT);
  assign load_val_o = wdata_i[CNT_W-1:0];
endmodule

// File: rtl/div_countdown_timer.sv
module div_countdown_timer
  import div_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int VEC_W     = 8,
  parameter int TICK_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_tick_i,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o
);
  logic             sw_en, vec_masked, periodic, init_wr, div_tick;
  logic [VEC_W-1:0] vec_num;
  logic [2:0]       shift;
  logic [CNT_W-1:0] load_val, init_val, cur_val;

  div_timer_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .init_i     (init_val),
    .cur_i      (cur_val),
    .rdata_o    (rdata_o),
    .sw_en_o    (sw_en),
    .masked_o   (vec_masked),
    .periodic_o (periodic),
    .vec_o      (vec_num),
    .shift_o    (shift),
    .load_o     (init_wr),
    .load_val_o (load_val)
  );

  div_timer_prescaler u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .restart_i   (init_wr),
    .base_tick_i (base_tick_i),
    .shift_i     (shift),
    .tick_o      (div_tick)
  );

  div_timer_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W), .TICK_STEP(TICK_STEP)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (init_wr),
    .load_val_i (load_val),
    .tick_i     (div_tick),
    .periodic_i (periodic),
    .masked_i   (vec_masked),
    .vec_i      (vec_num),
    .init_o     (init_val),
    .cur_o      (cur_val),
    .irq_o      (irq_o),
    .irq_vec_o  (irq_vec_o)
  );
endmodule

// File: rtl/div_countdown_timer_chk.sv
module div_countdown_timer_chk
  import div_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic [VEC_W-1:0]  irq_vec_o,
  input logic              sw_en,
  input logic              vec_masked,
  input logic              periodic,
  input logic [VEC_W-1:0]  vec_num,
  input logic              init_wr,
  input logic              div_tick,
  input logic [CNT_W-1:0]  init_val,
  input logic [CNT_W-1:0]  cur_val
);
  // R3
  zero_init_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(init_val) != '0);

  // R7
  masked_no_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !$past(vec_masked));

  // R7
  irq_vector_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_vec_o == $past(vec_num));

  // R8
  forced_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_VEC && !sw_en) |=> vec_masked);

  // R2
  init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_wr |=> cur_val == $past(wdata_i[CNT_W-1:0]));

  // R5
  oneshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!periodic && cur_val == '0 && !init_wr) |=> cur_val == '0);

  // R10
  cur_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_CUR && !div_tick) |=> $stable(cur_val));
endmodule

bind div_countdown_timer div_countdown_timer_chk #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .irq_vec_o  (irq_vec_o),
  .sw_en      (sw_en),
  .vec_masked (vec_masked),
  .periodic   (periodic),
  .vec_num    (vec_num),
  .init_wr    (init_wr),
  .div_tick   (div_tick),
  .init_val   (init_val),
  .cur_val    (cur_val)
);

// File: tb/div_countdown_timer_tb.sv
`timescale 1ns/1ps
module div_countdown_timer_tb;
  localparam int STEP = 4;

  logic        clk = 1'b0, rst_n = 1'b0, bt = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rd;
  logic        irq;
  logic [7:0]  ivec;

  always #2 clk = ~clk;

  div_countdown_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .base_tick_i(bt), .we_i(we), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rd), .irq_o(irq), .irq_vec_o(ivec)
  );

  int    n_chk = 0, n_err = 0;
  bit    done = 0;
  string tag = "R9";

  // bench model, state as seen after each clock edge
  bit          m_sw = 0, m_mask = 1, m_per = 0, m_irq = 0;
  logic [7:0]  m_vec = 0, m_ivec = 0;
  logic [2:0]  m_code = 0;
  logic [31:0] m_init = 0, m_cur = 0;
  int          m_pre = 0;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] r = '0;
    case (a)
      3'd0: r[0] = m_sw;
      3'd1: begin r[7:0] = m_vec; r[16] = m_mask; r[17] = m_per; end
      3'd2: r = m_init;
      3'd3: r = m_cur;
      3'd4: r[3:0] = {m_code[2], 1'b0, m_code[1:0]};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic int ratio_of(input logic [2:0] c);
    return (c == 3'b111) ? 1 : (2 << c);
  endfunction

  task automatic model_step(input bit w, input logic [2:0] a, input logic [31:0] d, input bit b);
    bit init_w, dtick;
    logic [31:0] left;
    init_w = w && a == 3'd2;
    dtick  = b && !init_w && (m_pre >= ratio_of(m_code) - 1);
    m_irq  = 0;
    if (init_w) m_pre = 0;
    else if (b) m_pre = dtick ? 0 : m_pre + 1;
    if (init_w) begin
      m_init = d; m_cur = d;
    end else if (dtick && m_init != 0 && (m_per || m_cur != 0)) begin
      if (m_cur <= STEP) begin
        m_irq = !m_mask;
        m_ivec = m_vec;
        left = STEP - m_cur;
        m_cur = m_per ? ((m_init > left) ? m_init - left : 0) : 0;
      end else m_cur = m_cur - STEP;
    end
    if (w) case (a)
      3'd0: m_sw = d[0];
      3'd1: begin m_vec = d[7:0]; m_mask = d[16] | !m_sw; m_per = d[17]; end
      3'd4: m_code = {d[3], d[1:0]};
      default: ;
    endcase
  endtask

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic cyc(input bit w, input logic [2:0] a, input logic [31:0] d, input bit b);
    @(negedge clk);
    check("irq", {31'b0, irq}, {31'b0, m_irq});
    if (m_irq) check("irq_vec", {24'b0, ivec}, {24'b0, m_ivec});
    check("rdata", rd, m_read(addr));
    we = w; addr = a; wd = d; bt = b;
    model_step(w, a, d, b);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1, a, d, 0);
  endtask

  task automatic run(input int n, input bit b, input logic [2:0] a);
    for (int i = 0; i < n; i++) cyc(0, a, 0, b);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R9";  // reset values of every register
    for (int a = 0; a < 6; a++) run(1, 0, 3'(a));

    tag = "R8";  // enable clear: written mask 0 stored as 1
    wr(3'd1, 32'h0000_0055); run(1, 0, 3'd1);
    wr(3'd0, 32'h1); wr(3'd1, 32'h0000_0042); run(1, 0, 3'd1);

    tag = "R11"; wr(3'd4, 32'hF); run(1, 0, 3'd4); run(1, 0, 3'd5);

    tag = "R3"; wr(3'd2, 0); run(20, 1, 3'd3);

    tag = "R5"; wr(3'd2, 10); run(12, 1, 3'd3);
    tag = "R2"; wr(3'd2, 9); run(6, 1, 3'd3);

    tag = "R6"; wr(3'd1, 32'h0002_0077);
    wr(3'd2, 10); run(30, 1, 3'd3);
    wr(3'd2, 6);  run(20, 1, 3'd3);
    wr(3'd2, 2);  run(10, 1, 3'd3);

    tag = "R10"; wr(3'd2, 40); run(2, 1, 3'd3);
    cyc(1, 3'd3, 32'h1234, 0); cyc(1, 3'd3, 32'h0, 1); run(2, 0, 3'd3);
    wr(3'd4, 32'h0); run(5, 1, 3'd3);
    wr(3'd4, 32'h3); run(40, 1, 3'd3);

    tag = "R1";
    for (int c = 0; c < 8; c++) begin
      logic [31:0] dv;
      dv = {28'b0, 1'(c >> 2), 1'b1, 2'(c)};  // bit 2 set, must be ignored
      wr(3'd4, dv); wr(3'd2, 8);
      run(6 * ratio_of(3'(c)) + 4, 1, 3'd3);
      run(1, 0, 3'd4);
    end

    tag = "R7"; wr(3'd4, 32'hB);
    wr(3'd1, 32'h0003_0099); wr(3'd2, 5); run(10, 1, 3'd3);
    wr(3'd1, 32'h0002_0099); run(10, 1, 3'd3);

    tag = "R4";
    for (int i = 0; i < 8000; i++) begin
      int unsigned r;
      logic [31:0] d;
      logic [2:0]  a;
      r = $urandom % 100;
      a = 3'($urandom % 6);
      if (r < 6) begin
        case (a)
          3'd0: d = {31'b0, 1'(($urandom % 5) != 0)};
          3'd2: d = (($urandom % 10) == 0) ? 0 : ($urandom % 48);
          3'd4: d = $urandom % 16;
          default: d = $urandom;
        endcase
        cyc(1, a, d, 1'($urandom % 4 != 0));
      end else cyc(0, a, 0, 1'($urandom % 4 != 0));
    end
    run(2, 0, 3'd3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule